// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the synchronized transmit-data level coming from a microcontroller and the control line of a single-wire bus driver. A low transmit level asks for a dominant bus. A high level leaves the driver off, so the bus stays recessive. The guard only passes a dominant request through while the transceiver is in its normal operating mode. It also stops the bus from being held dominant indefinitely: after a long continuous low on the transmit input, it cuts the driver off and keeps it off until the input has been high for a minimum time.

The same high-time qualification applies every time normal mode is entered. As a result, a transmit line that is stuck low at mode entry cannot take over the bus. A status output reports that a timeout has tripped. A forwarded copy of the raw transmit level is also provided for the mode controller, so a line that is stuck low can still select the low-power sleep path after a timeout. All durations are counted in ticks of an external tick-enable strobe.

Top module: `txd_dom_guard`

## Requirements
- R1: While in normal mode and armed, `drv_on_o` is 1 in the same cycle that `txd_i` is 0 and 0 in the same cycle that `txd_i` is 1 (0 = dominant request).
- R2: While `normal_i` is 0, `drv_on_o` is 0 regardless of `txd_i` and `tick_i`.
- R3: When armed in normal mode with `txd_i` held low, the tick that finds the low-time count already at TMO_TICKS trips the guard. This is the (TMO_TICKS+1)-th consecutive low tick. From the next cycle, `drv_on_o` is 0 even though `txd_i` stays low.
- R4: Any single cycle with `txd_i` high, with or without a tick, clears the low-time count.
- R5: A disarmed or tripped guard re-arms on the tick that finds the high-time count already at REARM_TICKS. This is the (REARM_TICKS+1)-th consecutive high tick in normal mode. Any low cycle clears the high-time count.
- R6: Entering normal mode always starts disarmed. High time seen outside normal mode does not count toward re-arming.
- R7: `trip_o` is 0 after reset. It goes to 1 on a trip, returns to 0 on re-arm, and otherwise holds its value, including while outside normal mode.
- R8: `txd_mode_o` equals `txd_i` in every cycle, whether or not the guard has tripped.
- R9: The low-time and high-time counts advance only in cycles with `tick_i` = 1. A low held for any number of cycles without ticks never trips.
- R10: If `txd_i` is high, or `normal_i` is low, in the cycle of the tick that would expire the timeout, no trip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base strobe; counts advance only when 1 |
| txd_i | input | 1 | Synchronized transmit level, 0 requests dominant |
| normal_i | input | 1 | 1 while the transceiver is in normal mode |
| drv_on_o | output | 1 | Bus driver command, 1 = drive dominant |
| trip_o | output | 1 | 1 while a timeout trip is pending re-arm |
| txd_mode_o | output | 1 | Unaltered transmit level for the mode controller |

## Verification
Two functions can act in the same clock edge. One is the tick that would expire the low-time window. The other is either the transmit line returning high or the mode flag falling. The bench holds the line low for exactly TMO_TICKS ticks and then, on the expiring tick, raises the line in one run and drops the mode flag in another. It then judges from `trip_o` and `drv_on_o` in the following cycle that no trip was recorded. A cycle-by-cycle reference model also covers the same coincidences when they arise in a long pseudo-random stretch of line, tick and mode activity.

// File: rtl/txd_dom_guard_pkg.sv
package txd_dom_guard_pkg;

    typedef enum logic [1:0] {
        GS_DISARMED = 2'd0,
        GS_ARMED    = 2'd1,
        GS_TRIPPED  = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic expire;
        logic qualify;
    } guard_evt_t;

    function automatic int cnt_bits(input int limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/sat_tick_counter.sv
module sat_tick_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic run_i,
    output logic hit_o
);
    import txd_dom_guard_pkg::*;

    localparam int CW = cnt_bits(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          at_lim;

    assign at_lim = (cnt_q == LIM);
    assign hit_o  = run_i & tick_i & at_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i && !at_lim) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/guard_state_ctl.sv
module guard_state_ctl
    import txd_dom_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       normal_i,
    input  guard_evt_t evt_i,
    output logic       armed_o,
    output logic       tripped_o
);

    guard_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_DISARMED: if (normal_i && evt_i.qualify) st_d = GS_ARMED;
            GS_ARMED: begin
                if (!normal_i)         st_d = GS_DISARMED;
                else if (evt_i.expire) st_d = GS_TRIPPED;
            end
            GS_TRIPPED:  if (normal_i && evt_i.qualify) st_d = GS_ARMED;
            default:     st_d = GS_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= GS_DISARMED;
        else     st_q <= st_d;
    end

    assign armed_o   = (st_q == GS_ARMED);
    assign tripped_o = (st_q == GS_TRIPPED);

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
    import txd_dom_guard_pkg::*;
#(
    parameter int TMO_TICKS   = 55000,
    parameter int REARM_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic txd_i,
    input  logic normal_i,
    output logic drv_on_o,
    output logic trip_o,
    output logic txd_mode_o
);

    logic       armed;
    logic       tripped;
    logic       low_run;
    logic       high_run;
    guard_evt_t evt;

    assign low_run  = normal_i & ~txd_i & armed;
    assign high_run = normal_i & txd_i;

    sat_tick_counter #(.LIMIT(TMO_TICKS)) u_low_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .run_i  (low_run),
        .hit_o  (evt.expire)
    );

    sat_tick_counter #(.LIMIT(REARM_TICKS)) u_high_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .run_i  (high_run),
        .hit_o  (evt.qualify)
    );

    guard_state_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .normal_i  (normal_i),
        .evt_i     (evt),
        .armed_o   (armed),
        .tripped_o (tripped)
    );

    assign drv_on_o   = normal_i & ~txd_i & armed;
    assign trip_o     = tripped;
    assign txd_mode_o = txd_i;

endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic txd_i,
    input logic normal_i,
    input logic drv_on_o,
    input logic trip_o,
    input logic txd_mode_o
);

    assert_off_outside_normal_R2: assert property (@(posedge clk) disable iff (rst)
        !normal_i |-> !drv_on_o);

    assert_high_is_recessive_R1: assert property (@(posedge clk) disable iff (rst)
        txd_i |-> !drv_on_o);

    assert_trip_cuts_driver_R3: assert property (@(posedge clk) disable iff (rst)
        trip_o |-> !drv_on_o);

    assert_forward_level_R8: assert property (@(posedge clk) disable iff (rst)
        txd_mode_o == txd_i);

    assert_no_trip_after_high_R10: assert property (@(posedge clk) disable iff (rst)
        txd_i |=> !$rose(trip_o));

    assert_no_trip_outside_normal_R10: assert property (@(posedge clk) disable iff (rst)
        !normal_i |=> !$rose(trip_o));

    assert_trip_needs_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(trip_o));

    assert_trip_held_outside_normal_R7: assert property (@(posedge clk) disable iff (rst)
        !normal_i |=> !$fell(trip_o));

endmodule

bind txd_dom_guard txd_dom_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .txd_i      (txd_i),
    .normal_i   (normal_i),
    .drv_on_o   (drv_on_o),
    .trip_o     (trip_o),
    .txd_mode_o (txd_mode_o)
);

// File: tb/txd_dom_guard_tb.sv
module txd_dom_guard_tb;

    localparam int TMO   = 6;
    localparam int REARM = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0;
    logic txd_i = 1'b1;
    logic normal_i = 1'b0;
    logic drv_on_o, trip_o, txd_mode_o;

    int checks = 0;
    int failures = 0;

    // reference model state
    int  m_lo = 0;
    int  m_hi = 0;
    bit  m_armed = 0;
    bit  m_trip = 0;

    always #10 clk = ~clk;

    txd_dom_guard #(.TMO_TICKS(TMO), .REARM_TICKS(REARM)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .txd_i      (txd_i),
        .normal_i   (normal_i),
        .drv_on_o   (drv_on_o),
        .trip_o     (trip_o),
        .txd_mode_o (txd_mode_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit lo_run, hi_run, expire, qual;
        if (rst) begin
            m_lo = 0; m_hi = 0; m_armed = 0; m_trip = 0;
            return;
        end
        lo_run = normal_i && !txd_i && m_armed;
        hi_run = normal_i && txd_i;
        expire = lo_run && tick_i && (m_lo >= TMO);
        qual   = hi_run && tick_i && (m_hi >= REARM);
        if (!lo_run) m_lo = 0;
        else if (tick_i && m_lo < TMO) m_lo++;
        if (!hi_run) m_hi = 0;
        else if (tick_i && m_hi < REARM) m_hi++;
        if (m_armed) begin
            if (!normal_i) m_armed = 0;
            else if (expire) begin m_armed = 0; m_trip = 1; end
        end else if (qual) begin
            m_armed = 1; m_trip = 0;
        end
    endtask

    task automatic step(input logic t, input logic n, input logic k);
        @(negedge clk);
        txd_i = t; normal_i = n; tick_i = k;
        #1;
        chk("R1/R2 drv_on_o model", drv_on_o, normal_i && !txd_i && m_armed);
        chk("R7 trip_o model", trip_o, m_trip);
        chk("R8 txd_mode_o model", txd_mode_o, txd_i);
        model_edge();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step(1'b0, 1'b1, 1'b1);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        chk("R7 reset trip", trip_o, 1'b0);
        chk("R2 off outside normal", drv_on_o, 1'b0);

        // entry with line stuck low
        repeat (10) step(1'b0, 1'b1, 1'b1);
        chk("R6 stuck low at entry", drv_on_o, 1'b0);

        // too short high time
        repeat (REARM) step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R5 short high not enough", drv_on_o, 1'b0);

        // qualifying high time
        repeat (REARM + 1) step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R1 low drives dominant", drv_on_o, 1'b1);
        repeat (TMO - 1) step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R3 still driving before expiry", drv_on_o, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R3 driver cut after timeout", drv_on_o, 1'b0);
        chk("R7 trip set", trip_o, 1'b1);
        chk("R8 stuck low still forwarded", txd_mode_o, 1'b0);

        // re-arm after trip
        repeat (REARM + 1) step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R5 trip cleared by re-arm", trip_o, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        chk("R1 driving again", drv_on_o, 1'b1);

        // one high cycle without tick clears the low count
        repeat (TMO - 2) step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        repeat (TMO) step(1'b0, 1'b1, 1'b1);
        chk("R4 low count cleared by high", drv_on_o, 1'b1);
        step(1'b1, 1'b1, 1'b1);

        // long low without ticks
        repeat (40) step(1'b0, 1'b1, 1'b0);
        chk("R9 no tick no trip drv", drv_on_o, 1'b1);
        chk("R9 no tick no trip flag", trip_o, 1'b0);
        step(1'b1, 1'b1, 1'b1);

        // coincidence: line high on expiring tick
        repeat (TMO) step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk("R10 high on expiry tick no trip", trip_o, 1'b0);
        chk("R10 still driving", drv_on_o, 1'b1);
        step(1'b1, 1'b1, 1'b1);

        // coincidence: mode drops on expiring tick
        repeat (TMO) step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R10 mode drop on expiry no trip", trip_o, 1'b0);
        chk("R2 off after mode drop", drv_on_o, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        chk("R6 re-entry disarmed", drv_on_o, 1'b0);

        // trip held outside normal, outside high time ignored
        repeat (REARM + 1) step(1'b1, 1'b1, 1'b1);
        repeat (TMO + 1) step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 trip held outside normal", trip_o, 1'b1);
        repeat (5) step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R6 outside high time not counted", trip_o, 1'b1);
        repeat (REARM) step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R5 re-armed in normal", trip_o, 1'b0);

        // pseudo-random stretch, model compared every cycle
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[3:0] > 4'd4 ? (lfsr[7:4] == 4'd0) : 1'b0,
                     lfsr[11:8] != 4'd0, lfsr[12] | lfsr[14]);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule